// File: doc/BRIEF.md
# Parallel LCD Bus Strobe Timer

This block drives the strobe-based parallel bus that links a host to an external display controller. Every transfer is framed by an active-low chip select, and it carries one active-low write or read strobe, a data/command select line and a bus of 8 or 16 bits. Software decides where each edge falls by writing two timing words of packed tick counts. The block applies the ordering rules between those fields, so that a sloppy setting still gives a well-formed bus cycle.

Requests arrive on a valid/ready port. There are three kinds: command write, parameter/data write and single read. A request is taken on a clock where both `req_valid` and `req_ready` are high. Each accepted request produces exactly one bus cycle. `req_ready` stays low from acceptance until the recovery gap after the cycle has elapsed. While it is low, a held request waits without being consumed and its fields may change freely. A read returns its data with a one-clock `rsp_valid` pulse. That pulse has no back-pressure: the host must take it when it appears.

Configuration pins are plain levels. They are sampled only at the clock where a request is accepted.

Top module: `lcd_strobe_timer`

## Requirements
- R1: One tick lasts one clock when `cfg_div2` is 0 and two clocks when it is 1. Tick 0 begins in the clock after acceptance. With division by two, every tick covers two whole clocks counted from acceptance.
- R2: Ticks count from 0 at the start of a cycle. CS is low while its assert tick ≤ tick < its release tick. The assert tick is `cfg_timing0[3:0]` and the release tick is `cfg_timing0[9:4]`. WE uses `[13:10]` and `[19:14]`, and is active in write cycles only. RE uses `[23:20]` and `[29:24]`, and is active in read cycles only.
- R3: A write cycle lasts max(write length `cfg_timing1[5:0]`, CS release) ticks. A read cycle lasts max(read length `cfg_timing1[11:6]`, CS release, access tick + 1) ticks. The access tick is `cfg_timing1[27:22]`. Both maxima use the adjusted values of R4.
- R4: A release tick that is not greater than its assert tick is raised to assert + 1. The CS release is then raised to the later of the adjusted WE and RE releases. Each cycle length is raised to at least its strobe's adjusted release.
- R5: A read captures the bus at the clock edge that ends the access tick. The access tick is raised to RE assert + 1 when it is not beyond RE assert. `rsp_valid` is high for exactly the one clock after the last tick of a read, with the data on `rsp_rdata`. Write cycles give no `rsp_valid`.
- R6: `cfg_width` = 3 selects a 16-bit bus. Any other value selects 8 bits. In 8-bit mode only the low byte is driven, the upper bits are 0, and read data has its upper byte zeroed.
- R7: `req_kind` 00 is a command, 01 is parameter/data and 1x is a read. `lcd_dc` is low throughout a command cycle and high at all other times.
- R8: `lcd_data_oe` is high, and `lcd_data_o` carries the write word, only during the ticks of a write cycle. At all other times the enable is low and `lcd_data_o` is 0.
- R9: After the last tick of a cycle, the block stays busy for `cfg_timing1[17:12]` further ticks. CS is high throughout that gap. `req_ready` is high only when idle, and a request held during busy starts nothing.
- R10: Timing, divider, width, kind and write data are captured at acceptance. Changes to them during a cycle do not affect it.
- R11: After reset, all strobes are high, `lcd_dc` is high, the bus is not driven, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_timing0 | input | 32 | Strobe edge ticks for CS, WE and RE |
| cfg_timing1 | input | 32 | Cycle lengths, recovery gap and read access tick |
| cfg_div2 | input | 1 | Tick equals two clocks when set |
| cfg_width | input | 2 | Bus width select: 3 selects 16 bits, other values select 8 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_kind | input | 2 | 00 command, 01 parameter/data, 1x read |
| req_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | One-clock read completion pulse |
| rsp_rdata | output | DATA_W | Captured read word |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_we_n | output | 1 | Write strobe, active low |
| lcd_re_n | output | 1 | Read strobe, active low |
| lcd_dc | output | 1 | Low for command, high otherwise |
| lcd_data_o | output | DATA_W | Bus output value |
| lcd_data_oe | output | 1 | Bus output enable |
| lcd_data_i | input | DATA_W | Bus input value |

## Verification
Two things meet in one clock: the end of the recovery gap, which raises `req_ready`, and a request that was already waiting. A second collision is a configuration change that lands while a cycle is running. To provoke the first, the bench keeps `req_valid` high with a different kind and word throughout a cycle and its gap. It then checks every clock against a tick model: the strobes must follow the first request only, and `req_ready` must rise in exactly the clock that the gap length predicts. To provoke the second, the bench inverts every configuration input early in a cycle and judges the whole waveform against the values captured at acceptance.

// File: rtl/lcdst_pkg.sv
package lcdst_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 6;
  localparam int TK_W  = OFF_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_GAP} seq_st_e;

  typedef struct packed {
    logic [TK_W-1:0] cs_on;
    logic [TK_W-1:0] cs_off;
    logic [TK_W-1:0] st_on;
    logic [TK_W-1:0] st_off;
    logic [TK_W-1:0] smp;
    logic [TK_W-1:0] last;
    logic [TK_W-1:0] gap;
  } win_t;
endpackage

// File: rtl/lcdst_timing_fix.sv
module lcdst_timing_fix
  import lcdst_pkg::*;
(
  input  logic [31:0] tw0,
  input  logic [31:0] tw1,
  input  logic        rd,
  output win_t        win
);
  function automatic logic [TK_W-1:0] vmax(input logic [TK_W-1:0] a, input logic [TK_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [TK_W-1:0] cs_on, cs_off_r, we_on, we_off_r, re_on, re_off_r;
  logic [TK_W-1:0] we_len, re_len, gap, acc_r;
  logic [TK_W-1:0] we_off, re_off, cs_off, acc, we_cyc, re_cyc;

  always_comb begin
    cs_on    = TK_W'(tw0[3:0]);
    cs_off_r = TK_W'(tw0[9:4]);
    we_on    = TK_W'(tw0[13:10]);
    we_off_r = TK_W'(tw0[19:14]);
    re_on    = TK_W'(tw0[23:20]);
    re_off_r = TK_W'(tw0[29:24]);
    we_len   = TK_W'(tw1[5:0]);
    re_len   = TK_W'(tw1[11:6]);
    gap      = TK_W'(tw1[17:12]);
    acc_r    = TK_W'(tw1[27:22]);

    // releases strictly after asserts
    we_off = (we_off_r > we_on) ? we_off_r : we_on + TK_W'(1);
    re_off = (re_off_r > re_on) ? re_off_r : re_on + TK_W'(1);
    cs_off = (cs_off_r > cs_on) ? cs_off_r : cs_on + TK_W'(1);
    // CS may not release before either strobe
    cs_off = vmax(cs_off, vmax(we_off, re_off));
    acc    = (acc_r > re_on) ? acc_r : re_on + TK_W'(1);
    we_cyc = vmax(we_len, we_off);
    re_cyc = vmax(re_len, re_off);

    win.cs_on  = cs_on;
    win.cs_off = cs_off;
    win.st_on  = rd ? re_on  : we_on;
    win.st_off = rd ? re_off : we_off;
    win.smp    = acc;
    win.gap    = gap;
    win.last   = rd ? vmax(vmax(re_cyc, cs_off), acc + TK_W'(1))
                    : vmax(we_cyc, cs_off);
  end
endmodule

// File: rtl/lcdst_tick_div.sv
module lcdst_tick_div (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic div2,
  output logic tick
);
  logic ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph <= 1'b0;
    else if (restart) ph <= 1'b0;
    else if (div2)    ph <= ~ph;
    else              ph <= 1'b0;
  end

  assign tick = !div2 || ph;

  // R1: with halving active, tick pulses never come on adjacent clocks
  p_tick_alternate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (div2 && tick && !restart) |=> !tick);
endmodule

// File: rtl/lcdst_seq.sv
module lcdst_seq
  import lcdst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic rd_in,
  input  win_t win_in,
  input  logic div2_in,
  input  logic tick,
  output logic ready,
  output logic active,
  output logic rd_q,
  output logic div2_q,
  output logic cs_n,
  output logic st_n,
  output logic smp_fire,
  output logic done_rd
);
  seq_st_e         st;
  logic [TK_W-1:0] t;
  win_t            w;
  logic            done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      t      <= '0;
      w      <= '0;
      rd_q   <= 1'b0;
      div2_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_fire) begin
          st     <= S_ACT;
          t      <= '0;
          w      <= win_in;
          rd_q   <= rd_in;
          div2_q <= div2_in;
        end
        S_ACT: if (tick) begin
          if (t == w.last - TK_W'(1)) begin
            t      <= '0;
            done_q <= rd_q;
            st     <= (w.gap == '0) ? S_IDLE : S_GAP;
          end else begin
            t <= t + TK_W'(1);
          end
        end
        S_GAP: if (tick) begin
          if (t == w.gap - TK_W'(1)) begin
            t  <= '0;
            st <= S_IDLE;
          end else begin
            t <= t + TK_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready    = (st == S_IDLE);
  assign active   = (st == S_ACT);
  assign cs_n     = !(active && t >= w.cs_on && t < w.cs_off);
  assign st_n     = !(active && t >= w.st_on && t < w.st_off);
  assign smp_fire = active && rd_q && tick && (t == w.smp);
  assign done_rd  = done_q;

  // R9: gap counter stays inside the programmed recovery window
  p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> (t < w.gap));
  // R5: the capture point lies inside the cycle
  p_sample_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_fire |-> (t < w.last));
endmodule

// File: rtl/lcd_strobe_timer.sv
module lcd_strobe_timer
  import lcdst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_timing0,
  input  logic [31:0]       cfg_timing1,
  input  logic              cfg_div2,
  input  logic [1:0]        cfg_width,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              lcd_cs_n,
  output logic              lcd_we_n,
  output logic              lcd_re_n,
  output logic              lcd_dc,
  output logic [DATA_W-1:0] lcd_data_o,
  output logic              lcd_data_oe,
  input  logic [DATA_W-1:0] lcd_data_i
);
  localparam int NARROW_W = DATA_W / 2;

  win_t win;
  logic fire, tick, active, rd_q, div2_q, cs_n, st_n, smp_fire, done_rd;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic cmd_q, wide_q;

  assign fire = req_valid && req_ready;

  lcdst_timing_fix u_fix (
    .tw0 (cfg_timing0),
    .tw1 (cfg_timing1),
    .rd  (req_kind[1]),
    .win (win)
  );

  lcdst_tick_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (fire),
    .div2    (div2_q),
    .tick    (tick)
  );

  lcdst_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (fire),
    .rd_in    (req_kind[1]),
    .win_in   (win),
    .div2_in  (cfg_div2),
    .tick     (tick),
    .ready    (req_ready),
    .active   (active),
    .rd_q     (rd_q),
    .div2_q   (div2_q),
    .cs_n     (cs_n),
    .st_n     (st_n),
    .smp_fire (smp_fire),
    .done_rd  (done_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      cmd_q   <= 1'b0;
      wide_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (fire) begin
        wdata_q <= req_wdata;
        cmd_q   <= (req_kind == 2'b00);
        wide_q  <= (cfg_width == 2'b11);
      end
      if (smp_fire)
        rdata_q <= wide_q ? lcd_data_i : {{(DATA_W-NARROW_W){1'b0}}, lcd_data_i[NARROW_W-1:0]};
    end
  end

  assign lcd_cs_n    = cs_n;
  assign lcd_we_n    = rd_q ? 1'b1 : st_n;
  assign lcd_re_n    = rd_q ? st_n : 1'b1;
  assign lcd_dc      = !(active && cmd_q);
  assign lcd_data_oe = active && !rd_q;
  assign lcd_data_o  = !lcd_data_oe ? '0 :
                       wide_q ? wdata_q : {{(DATA_W-NARROW_W){1'b0}}, wdata_q[NARROW_W-1:0]};
  assign rsp_valid   = done_rd;
  assign rsp_rdata   = rdata_q;

  // R9: chip select is never low while the block offers to accept
  p_ready_cs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> lcd_cs_n);
  // R9: an accepted request makes the block busy on the next clock
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !req_ready);
  // R8: the bus is never driven while the read strobe is low
  p_oe_excl_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_re_n |-> !lcd_data_oe);
  // R5: completion is a single-clock pulse
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/tb_lcd_strobe_timer.sv
module tb_lcd_strobe_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_timing0 = '0, cfg_timing1 = '0;
  logic cfg_div2 = 1'b0;
  logic [1:0] cfg_width = 2'b11;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = 2'b00;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic lcd_cs_n, lcd_we_n, lcd_re_n, lcd_dc, lcd_data_oe;
  logic [DW-1:0] lcd_data_o;
  logic [DW-1:0] lcd_data_i = '0;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_strobe_timer #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_timing0(cfg_timing0), .cfg_timing1(cfg_timing1),
    .cfg_div2(cfg_div2), .cfg_width(cfg_width), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .lcd_cs_n(lcd_cs_n), .lcd_we_n(lcd_we_n), .lcd_re_n(lcd_re_n), .lcd_dc(lcd_dc),
    .lcd_data_o(lcd_data_o), .lcd_data_oe(lcd_data_oe), .lcd_data_i(lcd_data_i)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pack0(int cson, int csoff, int weon, int weoff, int reon, int reoff);
    return {2'b00, 6'(reoff), 4'(reon), 6'(weoff), 4'(weon), 6'(csoff), 4'(cson)};
  endfunction

  function automatic logic [31:0] pack1(int wcyc, int rcyc, int gap, int acc);
    return {4'h0, 6'(acc), 4'h0, 6'(gap), 6'(rcyc), 6'(wcyc)};
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // independent tick model of the ordering rules
  task automatic model(input logic [31:0] t0, input logic [31:0] t1, input bit rd,
                       output int cson, output int csoff, output int son, output int soff,
                       output int smp, output int last, output int gap);
    int weon, weoff, reon, reoff, wc, rc;
    cson = int'(t0[3:0]);   csoff = int'(t0[9:4]);
    weon = int'(t0[13:10]); weoff = int'(t0[19:14]);
    reon = int'(t0[23:20]); reoff = int'(t0[29:24]);
    if (weoff <= weon) weoff = weon + 1;
    if (reoff <= reon) reoff = reon + 1;
    if (csoff <= cson) csoff = cson + 1;
    csoff = imax(csoff, imax(weoff, reoff));
    smp = int'(t1[27:22]);
    if (smp <= reon) smp = reon + 1;
    wc = imax(int'(t1[5:0]), weoff);
    rc = imax(int'(t1[11:6]), reoff);
    gap = int'(t1[17:12]);
    son  = rd ? reon : weon;
    soff = rd ? reoff : weoff;
    last = rd ? imax(imax(rc, csoff), smp + 1) : imax(wc, csoff);
  endtask

  task automatic run_cycle(input string tag, input logic [1:0] kind, input logic [DW-1:0] wd,
                           input logic [31:0] t0, input logic [31:0] t1, input bit d2,
                           input logic [1:0] wsel, input bit disturb, input bit hold);
    bit rd, wide, act, idl;
    int cson, csoff, son, soff, smp, last, gap, dv, a_clk, g_clk, n, tk;
    logic [DW-1:0] exp_do, exp_rd;
    rd = kind[1];
    wide = (wsel == 2'b11);
    model(t0, t1, rd, cson, csoff, son, soff, smp, last, gap);
    dv = d2 ? 2 : 1;
    a_clk = last * dv;
    g_clk = gap * dv;
    n = a_clk + g_clk + 3;
    @(negedge clk);
    cfg_timing0 = t0; cfg_timing1 = t1; cfg_div2 = d2; cfg_width = wsel;
    req_kind = kind; req_wdata = wd; req_valid = 1'b1;
    chk({"R9 ", tag}, "ready before request", 32'(req_ready), 32'd1);
    @(posedge clk);
    #1;
    if (hold) begin
      req_kind = 2'b00;
      req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tk = k / dv;
      act = (k < a_clk);
      idl = (k >= a_clk + g_clk);
      exp_do = !(act && !rd) ? '0 : wide ? wd : {8'h00, wd[7:0]};
      chk({"R2 ", tag}, "cs_n", 32'(lcd_cs_n), 32'(!(act && tk >= cson && tk < csoff)));
      chk({"R2 ", tag}, "we_n", 32'(lcd_we_n), 32'(!(act && !rd && tk >= son && tk < soff)));
      chk({"R2 ", tag}, "re_n", 32'(lcd_re_n), 32'(!(act && rd && tk >= son && tk < soff)));
      chk({"R7 ", tag}, "dc", 32'(lcd_dc), 32'(!(act && kind == 2'b00)));
      chk({"R8 ", tag}, "data_oe", 32'(lcd_data_oe), 32'(act && !rd));
      chk({"R6 ", tag}, "data_o", 32'(lcd_data_o), 32'(exp_do));
      chk({"R3 ", tag}, "ready", 32'(req_ready), 32'(idl));
      chk({"R5 ", tag}, "rsp_valid", 32'(rsp_valid), 32'(rd && k == a_clk));
      lcd_data_i = 16'h5A00 | 16'(tk);
      if (disturb && k == 1) begin
        cfg_timing0 = ~t0; cfg_timing1 = ~t1; cfg_div2 = ~d2; cfg_width = ~wsel;
      end
      if (hold && k == a_clk + g_clk) req_valid = 1'b0;
    end
    if (rd) begin
      exp_rd = wide ? (16'h5A00 | 16'(smp)) : 16'(smp[7:0]);
      chk({"R5 ", tag}, "rsp_rdata", 32'(rsp_rdata), 32'(exp_rd));
    end
    cfg_timing0 = t0; cfg_timing1 = t1; cfg_div2 = d2; cfg_width = wsel;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11", "cs_n", 32'(lcd_cs_n), 32'd1);
    chk("R11", "we_n", 32'(lcd_we_n), 32'd1);
    chk("R11", "re_n", 32'(lcd_re_n), 32'd1);
    chk("R11", "dc", 32'(lcd_dc), 32'd1);
    chk("R11", "data_oe", 32'(lcd_data_oe), 32'd0);
    chk("R11", "ready", 32'(req_ready), 32'd1);
    chk("R11", "rsp_valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_cmd_wide;   // R2 R3 R7 command, 16 bits, single clock tick
    run_cycle("R2", 2'b00, 16'h3C5A, pack0(1, 6, 2, 5, 1, 4), pack1(7, 6, 2, 4), 1'b0, 2'b11, 1'b0, 1'b0);
  endtask
  task automatic t_data_narrow_div2;   // R1 R6 data write, 8 bits, halved tick
    run_cycle("R1", 2'b01, 16'hBEEF, pack0(0, 4, 1, 3, 0, 2), pack1(5, 5, 1, 3), 1'b1, 2'b00, 1'b0, 1'b0);
  endtask
  task automatic t_read_wide;   // R3 R5 read with length set by read cycle field
    run_cycle("R3", 2'b10, 16'h0000, pack0(1, 8, 0, 2, 2, 7), pack1(3, 9, 3, 5), 1'b0, 2'b11, 1'b0, 1'b0);
  endtask
  task automatic t_read_narrow_div2;   // R1 R5 R6 read, no gap, halved tick
    run_cycle("R5", 2'b11, 16'h0000, pack0(0, 5, 0, 1, 1, 4), pack1(2, 4, 0, 3), 1'b1, 2'b00, 1'b0, 1'b0);
  endtask
  task automatic t_clamp_write;   // R4 release fixes, CS raised, length raised
    run_cycle("R4", 2'b01, 16'h1234, pack0(3, 2, 4, 4, 5, 9), pack1(0, 0, 1, 0), 1'b0, 2'b11, 1'b0, 1'b0);
  endtask
  task automatic t_clamp_read;   // R4 R5 access and read length raised
    run_cycle("R4", 2'b10, 16'h0000, pack0(0, 1, 0, 1, 6, 3), pack1(0, 1, 0, 2), 1'b0, 2'b11, 1'b0, 1'b0);
  endtask
  task automatic t_cfg_change;   // R10 config changed mid-cycle
    run_cycle("R10", 2'b00, 16'hA55A, pack0(2, 7, 3, 6, 0, 1), pack1(8, 2, 3, 1), 1'b0, 2'b11, 1'b1, 1'b0);
  endtask
  task automatic t_hold_request;   // R9 request held through busy
    run_cycle("R9", 2'b01, 16'hC0DE, pack0(1, 5, 1, 4, 0, 1), pack1(6, 2, 4, 1), 1'b0, 2'b11, 1'b0, 1'b1);
  endtask
  task automatic t_width_odd;   // R6 width value 1 means 8 bits
    run_cycle("R6", 2'b10, 16'h0000, pack0(0, 4, 0, 1, 1, 4), pack1(0, 4, 1, 2), 1'b0, 2'b01, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cmd_wide();
    t_data_narrow_div2();
    t_read_wide();
    t_read_narrow_div2();
    t_clamp_write();
    t_clamp_read();
    t_cfg_change();
    t_hold_request();
    t_width_odd();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule